// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches sixteen recent virtual-to-physical page translations for a 32-bit address space with 4 KiB pages. A lookup presents a virtual address. All sixteen stored page tags are compared at once, and in the same cycle the block reports a hit or a miss. On a hit it also gives the physical address and a write-protection fault flag. A hit marks the entry as referenced. A permitted write also marks it as modified. A write to a page that does not allow writes is flagged and does not mark the entry.

On a miss, the surrounding page-walk logic fetches the translation and installs it through the refill port. The block picks the slot to use in this order:
- the slot that already holds the same page,
- otherwise the lowest free slot,
- otherwise the slot named by a free-running pseudo-random sequence.

While the refill is being presented, the status of the entry being displaced is shown on the eviction outputs, so that it can be copied back to the page table. A flush input invalidates every entry in a single cycle.

Top module: `tlb_fa`

## Requirements
- R1: Sixteen entries are searched in parallel. `lk_hit` is high in the same cycle as `lk_valid` when a valid entry's tag equals `lk_vaddr[31:12]`. `lk_miss` is high when `lk_valid` is high and no valid entry matches. Both are low when `lk_valid` is low.
- R2: On a hit, `lk_paddr` is the entry's 20-bit physical page number in bits [31:12] and `lk_vaddr[11:0]` unchanged in bits [11:0]. When there is no hit, `lk_paddr` is zero.
- R3: A hit sets the entry's referenced bit at the next clock edge.
- R4: A write hit to an entry whose write-allowed bit is 1 sets its modified bit at the next edge. A faulting write leaves the modified bit unchanged.
- R5: `lk_fault` is high in the lookup cycle exactly when a write hits an entry whose write-allowed bit is 0. `lk_hit` stays high in that cycle.
- R6: A refill writes its slot at the next edge. The slot is chosen in this order: the valid entry holding `fill_vpn`; otherwise the lowest-indexed invalid entry; otherwise the entry whose index equals the current pseudo-random state.
- R7: The pseudo-random state is 4 bits. It is 0 after reset and advances on every clock edge to {s[2:0], s[3]^s[2]^(s[2:0]==0)}. It visits all 16 values.
- R8: During a refill cycle without flush, `ev_valid` is 1 exactly when the chosen slot currently holds a valid entry. In that case `ev_ref`, `ev_dirty` and `ev_vpn` give that entry's stored referenced bit, modified bit and tag, read before this cycle's updates. Otherwise all four eviction outputs are 0.
- R9: A newly installed entry starts with its referenced and modified bits at 0, and takes its write-allowed bit from `fill_wr_ok`.
- R10: `flush` invalidates all entries at the next edge. A refill presented in the same cycle is ignored and produces no eviction output.
- R11: After reset, every entry is invalid.
- R12: If a hit and a refill select the same slot in one cycle, the refill's fresh contents win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a store |
| lk_vaddr | input | 32 | Virtual byte address |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent; refill needed |
| lk_fault | output | 1 | Write to a write-protected page |
| lk_paddr | output | 32 | Physical byte address on hit |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_wr_ok | input | 1 | Write-allowed bit for the new entry |
| flush | input | 1 | Invalidate all entries |
| ev_valid | output | 1 | Displaced entry was valid |
| ev_ref | output | 1 | Displaced entry's referenced bit |
| ev_dirty | output | 1 | Displaced entry's modified bit |
| ev_vpn | output | 20 | Displaced entry's virtual page number |

## Verification
The checker relies on the stimulus keeping `fill_vpn` unique per slot, which holds because every refill goes through the block's own same-page search. It also relies on no input ever being X once reset is released, and the bench drives every input to a defined value from time zero. Lookups, refills and flushes are drawn from a small pool of 24 page numbers. With 16 slots, this makes same-page overwrites, evictions from a full table, and same-cycle hit/refill collisions frequent. Writes are mixed with reads across both write-allowed settings.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int unsigned ENTRIES = 16;
    localparam int unsigned IDX_W   = $clog2(ENTRIES);
    localparam int unsigned VA_W    = 32;
    localparam int unsigned OFF_W   = 12;
    localparam int unsigned VPN_W   = VA_W - OFF_W;
    localparam int unsigned PPN_W   = 20;
    localparam int unsigned PA_W    = PPN_W + OFF_W;

    typedef struct packed {
        logic             vld;
        logic             rbit;
        logic             dirty;
        logic             wr_ok;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] state_o
);
    typedef struct packed {
        logic [IDX_W-1:0] sr;
    } lfsr_t;

    lfsr_t s_d, s_q;

    // taps 3,2 with the all-zero extension so every index is reachable
    always_comb begin
        s_d    = s_q;
        s_d.sr = {s_q.sr[IDX_W-2:0],
                  s_q.sr[IDX_W-1] ^ s_q.sr[IDX_W-2] ^ ~(|s_q.sr[IDX_W-2:0])};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign state_o = s_q.sr;
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0]            vld_i,
    input  logic [ENTRIES-1:0][VPN_W-1:0] vpn_i,
    input  logic [VPN_W-1:0]              key_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              idx_o
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = vld_i[g] && (vpn_i[g] == key_i);
    end

    always_comb begin
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IDX_W'(i);
        end
    end

    assign hit_o = |eq;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0] vld_i,
    input  logic               same_hit_i,
    input  logic [IDX_W-1:0]   same_idx_i,
    input  logic [IDX_W-1:0]   rnd_i,
    output logic [IDX_W-1:0]   tgt_o
);
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    always_comb begin
        if (same_hit_i)    tgt_o = same_idx_i;
        else if (any_free) tgt_o = free_idx;
        else               tgt_o = rnd_i;
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    output logic [PA_W-1:0]  lk_paddr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wr_ok,
    input  logic             flush,
    output logic             ev_valid,
    output logic             ev_ref,
    output logic             ev_dirty,
    output logic [VPN_W-1:0] ev_vpn
);
    typedef struct packed {
        tlb_entry_t [ENTRIES-1:0] ent;
    } tlb_state_t;

    tlb_state_t st_d, st_q;

    logic [ENTRIES-1:0]            vld_vec;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_vec;
    logic                          lk_any, same_any;
    logic [IDX_W-1:0]              lk_idx, same_idx, rnd_idx, tgt_idx;
    tlb_entry_t                    hit_ent, vic_ent, new_ent;
    logic                          fill_go;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
        assign vld_vec[g] = st_q.ent[g].vld;
        assign vpn_vec[g] = st_q.ent[g].vpn;
    end

    tlb_cam u_cam_lk (
        .vld_i (vld_vec),
        .vpn_i (vpn_vec),
        .key_i (lk_vaddr[VA_W-1:OFF_W]),
        .hit_o (lk_any),
        .idx_o (lk_idx)
    );

    tlb_cam u_cam_fill (
        .vld_i (vld_vec),
        .vpn_i (vpn_vec),
        .key_i (fill_vpn),
        .hit_o (same_any),
        .idx_o (same_idx)
    );

    tlb_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (rnd_idx)
    );

    tlb_victim u_victim (
        .vld_i      (vld_vec),
        .same_hit_i (same_any),
        .same_idx_i (same_idx),
        .rnd_i      (rnd_idx),
        .tgt_o      (tgt_idx)
    );

    // lookup side, same cycle
    assign hit_ent  = st_q.ent[lk_idx];
    assign lk_hit   = lk_valid && lk_any;
    assign lk_miss  = lk_valid && !lk_any;
    assign lk_fault = lk_hit && lk_write && !hit_ent.wr_ok;
    assign lk_paddr = lk_hit ? {hit_ent.ppn, lk_vaddr[OFF_W-1:0]} : '0;

    // refill side, eviction report
    assign fill_go  = fill_valid && !flush;
    assign vic_ent  = st_q.ent[tgt_idx];
    assign ev_valid = fill_go && vic_ent.vld;
    assign ev_ref   = ev_valid && vic_ent.rbit;
    assign ev_dirty = ev_valid && vic_ent.dirty;
    assign ev_vpn   = ev_valid ? vic_ent.vpn : '0;

    always_comb begin
        new_ent       = '0;
        new_ent.vld   = 1'b1;
        new_ent.wr_ok = fill_wr_ok;
        new_ent.vpn   = fill_vpn;
        new_ent.ppn   = fill_ppn;
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) st_d.ent[i].vld = 1'b0;
        end else begin
            if (lk_hit) begin
                st_d.ent[lk_idx].rbit = 1'b1;
                if (lk_write && hit_ent.wr_ok) st_d.ent[lk_idx].dirty = 1'b1;
            end
            if (fill_valid) st_d.ent[tgt_idx] = new_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_write,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic [PA_W-1:0]  lk_paddr,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic [PPN_W-1:0] fill_ppn,
    input logic             fill_wr_ok,
    input logic             flush,
    input logic             ev_valid,
    input logic             ev_ref,
    input logic             ev_dirty,
    input logic [VPN_W-1:0] ev_vpn
);
    // R1
    hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_miss));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    // R2
    miss_paddr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_paddr == '0));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R5
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && lk_write));

    // R8
    ev_only_on_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (fill_valid && !flush));

    // R8
    ev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |-> (!ev_ref && !ev_dirty && ev_vpn == '0));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R6
    fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=>
            (!(lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) ||
             (lk_hit && lk_paddr[PA_W-1:OFF_W] == $past(fill_ppn) &&
              lk_fault == (lk_write && !$past(fill_wr_ok)))));
endmodule

bind tlb_fa tlb_fa_chk u_chk (.*);

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
    import tlb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0]      lk_vaddr = '0;
    logic             lk_hit, lk_miss, lk_fault;
    logic [31:0]      lk_paddr;
    logic             fill_valid = 1'b0, fill_wr_ok = 1'b0, flush = 1'b0;
    logic [19:0]      fill_vpn = '0, fill_ppn = '0;
    logic             ev_valid, ev_ref, ev_dirty;
    logic [19:0]      ev_vpn;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_wr_ok(fill_wr_ok), .flush(flush),
        .ev_valid(ev_valid), .ev_ref(ev_ref), .ev_dirty(ev_dirty), .ev_vpn(ev_vpn)
    );

    // behavioural reference
    bit        m_vld[16], m_ref[16], m_dirty[16], m_wok[16];
    bit [19:0] m_vpn[16], m_ppn[16];
    int        m_lfsr;
    int        n_chk = 0, n_fail = 0;
    bit        done = 0;

    function automatic int m_find(input logic [19:0] v);
        for (int i = 0; i < 16; i++) if (m_vld[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic int m_target(input logic [19:0] v);
        int f;
        f = m_find(v);
        if (f >= 0) return f;
        for (int i = 0; i < 16; i++) if (!m_vld[i]) return i;
        return m_lfsr;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int  h, t;
        bit  e_hit, e_fault, e_ev, fg, full;
        logic [31:0] e_pa;
        h       = lk_valid ? m_find(lk_vaddr[31:12]) : -1;
        e_hit   = (h >= 0);
        e_pa    = e_hit ? {m_ppn[h], lk_vaddr[11:0]} : 32'h0;
        e_fault = e_hit && lk_write && !m_wok[h];
        chk(lk_hit == e_hit, "R1", "hit", 64'(lk_hit), 64'(e_hit));
        chk(lk_miss == (lk_valid && !e_hit), "R1", "miss", 64'(lk_miss), 64'(lk_valid && !e_hit));
        chk(lk_paddr == e_pa, "R2", "paddr", 64'(lk_paddr), 64'(e_pa));
        chk(lk_fault == e_fault, "R5", "fault", 64'(lk_fault), 64'(e_fault));
        fg   = fill_valid && !flush;
        t    = m_target(fill_vpn);
        full = 1;
        for (int i = 0; i < 16; i++) if (!m_vld[i]) full = 0;
        e_ev = fg && m_vld[t];
        chk(ev_valid == e_ev, "R8", "ev_valid", 64'(ev_valid), 64'(e_ev));
        chk(ev_ref == (e_ev && m_ref[t]), "R3", "ev_ref", 64'(ev_ref), 64'(e_ev && m_ref[t]));
        chk(ev_dirty == (e_ev && m_dirty[t]), "R4", "ev_dirty", 64'(ev_dirty), 64'(e_ev && m_dirty[t]));
        chk(ev_vpn == (e_ev ? m_vpn[t] : 20'h0),
            (full && m_find(fill_vpn) < 0) ? "R7" : "R6", "ev_vpn",
            64'(ev_vpn), 64'(e_ev ? m_vpn[t] : 20'h0));
    endtask

    always @(posedge clk) begin
        int h, t, fb;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) begin
                m_vld[i] = 0; m_ref[i] = 0; m_dirty[i] = 0; m_wok[i] = 0;
                m_vpn[i] = '0; m_ppn[i] = '0;
            end
            m_lfsr = 0;
        end else begin
            h = lk_valid ? m_find(lk_vaddr[31:12]) : -1;
            t = m_target(fill_vpn);
            if (flush) begin
                for (int i = 0; i < 16; i++) m_vld[i] = 0;
            end else begin
                if (h >= 0) begin
                    m_ref[h] = 1;
                    if (lk_write && m_wok[h]) m_dirty[h] = 1;
                end
                if (fill_valid) begin
                    m_vld[t] = 1; m_ref[t] = 0; m_dirty[t] = 0;
                    m_wok[t] = fill_wr_ok; m_vpn[t] = fill_vpn; m_ppn[t] = fill_ppn;
                end
            end
            fb = ((m_lfsr >> 3) & 1) ^ ((m_lfsr >> 2) & 1) ^ ((m_lfsr & 7) == 0 ? 1 : 0);
            m_lfsr = ((m_lfsr << 1) & 15) | fb;
        end
    end

    task automatic cyc(input bit lv, input bit lw, input logic [19:0] lvpn, input logic [11:0] off,
                       input bit fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                       input bit fwok, input bit fl);
        @(negedge clk);
        lk_valid = lv; lk_write = lw; lk_vaddr = {lvpn, off};
        fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_wr_ok = fwok; flush = fl;
        #1;
        compare();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: nothing valid after reset
        cyc(1, 0, 20'h00100, 12'h000, 0, 0, 0, 0, 0);
        chk(lk_miss == 1'b1, "R11", "miss after reset", 64'(lk_miss), 64'd1);

        // fill all sixteen slots, looking up the previous page each time
        for (int i = 0; i < 16; i++)
            cyc(i > 0, 0, 20'h00100 + 20'(i) - 20'd1, 12'hABC,
                1, 20'h00100 + 20'(i), 20'h5A000 + 20'(i), i[0], 0);
        cyc(1, 0, 20'h0010F, 12'h123, 0, 0, 0, 0, 0);
        chk(lk_paddr == 32'h5A00F123, "R2", "paddr slot15", 64'(lk_paddr), 64'h5A00F123);

        // R5: write to write-protected page
        cyc(1, 0, 20'h00102, 12'h010, 0, 0, 0, 0, 0);
        cyc(1, 1, 20'h00102, 12'h014, 0, 0, 0, 0, 0);
        chk(lk_fault == 1'b1 && lk_hit == 1'b1, "R5", "fault+hit", 64'({lk_fault, lk_hit}), 64'd3);
        cyc(1, 1, 20'h00103, 12'h020, 0, 0, 0, 0, 0);
        chk(lk_fault == 1'b0, "R5", "allowed write", 64'(lk_fault), 64'd0);

        // R3/R4: overwrite same page exposes status
        cyc(0, 0, 0, 0, 1, 20'h00102, 20'h6B002, 1, 0);
        chk(ev_ref == 1'b1 && ev_dirty == 1'b0, "R4", "faulted write not dirty",
            64'({ev_ref, ev_dirty}), 64'd2);
        cyc(0, 0, 0, 0, 1, 20'h00103, 20'h6B003, 1, 0);
        chk(ev_dirty == 1'b1, "R4", "allowed write dirty", 64'(ev_dirty), 64'd1);
        cyc(0, 0, 0, 0, 1, 20'h00103, 20'h6B003, 1, 0);
        chk(ev_ref == 1'b0 && ev_dirty == 1'b0, "R9", "fresh entry status",
            64'({ev_ref, ev_dirty}), 64'd0);

        // R12: hit and refill on the same slot in one cycle
        cyc(1, 1, 20'h00105, 12'h000, 1, 20'h00105, 20'h6B005, 1, 0);
        cyc(0, 0, 0, 0, 1, 20'h00105, 20'h6B005, 1, 0);
        chk(ev_ref == 1'b0 && ev_dirty == 1'b0, "R12", "refill wins",
            64'({ev_ref, ev_dirty}), 64'd0);

        // R7: full table, random victim
        cyc(0, 0, 0, 0, 1, 20'h00200, 20'h7C200, 1, 0);
        chk(ev_valid == 1'b1, "R7", "full-table eviction", 64'(ev_valid), 64'd1);

        // R10: flush ignores simultaneous refill
        cyc(0, 0, 0, 0, 1, 20'h00300, 20'h7C300, 1, 1);
        chk(ev_valid == 1'b0, "R10", "no eviction on flush", 64'(ev_valid), 64'd0);
        cyc(1, 0, 20'h00300, 12'h000, 0, 0, 0, 0, 0);
        chk(lk_miss == 1'b1, "R10", "refill dropped", 64'(lk_miss), 64'd1);
        cyc(1, 0, 20'h00101, 12'h000, 1, 20'h00400, 20'h7C400, 0, 0);
        chk(lk_miss == 1'b1 && ev_valid == 1'b0, "R10", "all invalid",
            64'({lk_miss, ev_valid}), 64'd2);
        cyc(1, 1, 20'h00400, 12'hFFF, 0, 0, 0, 0, 0);
        chk(lk_paddr == 32'h7C400FFF && lk_fault == 1'b1, "R6", "refill after flush",
            64'({lk_paddr, lk_fault}), 64'({32'h7C400FFF, 1'b1}));

        // mixed traffic
        for (int n = 0; n < 4000; n++) begin
            cyc($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
                20'h00100 + 20'($urandom_range(0, 23)), 12'($urandom),
                $urandom_range(0, 3) == 0, 20'h00100 + 20'($urandom_range(0, 23)),
                20'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 63) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule